// File: doc/BRIEF.md
# Shared Serial Port Select Sequencer

This block lets one synchronous serial master serve three peripherals, each behind its own active-low select line: a touch controller (device 0), an ADC (device 1) and a backlight timing device (device 2). A host pulses `start_i` with a device number and a data word. Later it pulses `stop_i`. Between those two pulses the chosen device stays selected and the block reports busy.

On a start, the sequencer first turns the serial engine off and drives every select high. It then loads the frame profile for the chosen device and enables the engine with that profile. Only after this does it pull the chosen select low.

- The touch controller is reached over a half-duplex Microwire-style frame: an 8-bit command, one turnaround clock, then a 12-bit reply, with the divider at 7.
- The ADC profile is an 8-bit full-duplex SPI frame with the divider at 4.
- For the ADC and the backlight device the block only selects; it shifts no word.

On stop for the touch controller, the block waits for the reply word to be complete and returns it. For the other two devices the result is zero. A stop always releases every select.

Top module: `cs_seq_top`

## Requirements
- R1: Out of reset all three selects `cs_n_o` are high, `sclk_o` is low, and `busy_o`, `err_o` and `done_o` are low.
- R2: Device codes are 0 = touch (`cs_n_o[0]`), 1 = ADC (`cs_n_o[1]`), 2 = backlight (`cs_n_o[2]`) and 3 = invalid. After the clock edge that accepts a start, all selects are high for one cycle. From the next edge on, only the chosen select is low.
- R3: A touch transaction drives one frame. `sclk_o` idles low and each of its half periods lasts 7 clock cycles. The command, `data_i[7:0]`, is sent MSB first on `mosi_o`, valid while `sclk_o` is high. One turnaround clock follows, then 12 reply bits are sampled from `miso_i` at rising `sclk_o`, MSB first. The frame has 21 rising edges in total.
- R4: While the ADC or the backlight device is selected, `sclk_o` makes no pulse.
- R5: A stop for the touch controller completes only once the whole reply has been received, including when the stop arrives mid-frame. At completion `rdata_o` holds the 12-bit reply and `done_o` pulses.
- R6: A stop for the ADC or the backlight device completes at the clock edge that samples it, with `rdata_o` equal to zero and a `done_o` pulse.
- R7: At the edge where `done_o` rises, all three selects go high and `busy_o` falls.
- R8: A start with device code 3 asserts no select and leaves `busy_o` low. It makes `err_o` high for exactly one cycle.
- R9: `busy_o` is high from the edge that accepts a start until stop completion. A start that arrives while busy is ignored: the selects do not change and no clock pulses follow.
- R10: A stop while idle has no effect: no `done_o` pulse, and the selects stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| dev_i | input | 2 | Device number for start |
| data_i | input | DW | Word sent to the touch controller |
| busy_o | output | 1 | Transaction in progress |
| err_o | output | 1 | One-cycle pulse on invalid device number |
| done_o | output | 1 | One-cycle pulse at stop completion |
| rdata_o | output | DW | Result of the last completed transaction |
| cs_n_o | output | 3 | Active-low device selects |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Touch transactions are run with different commands and replies: 0xA5/0xABC, an all-ones command with an all-ones reply, and 0x83/0x001. These show whether the command is shifted MSB first and whether the reply lands aligned rather than shifted by the turnaround bit. One touch transaction is stopped mid-frame and the others after the frame, which shows whether stop really waits for reply completion. ADC and backlight transactions show that only the right select drops, that no clock runs, and that the result is forced to zero. An invalid device code, a start issued while busy, and a stop issued while idle each check that the stray command leaves the selects and the result untouched.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
    localparam int NDEV     = 3;
    localparam int DEVW     = 2;
    localparam int CFG_WW   = 5;
    localparam int CFG_DIVW = 4;

    localparam logic [DEVW-1:0] DEV_TOUCH = 2'd0;
    localparam logic [DEVW-1:0] DEV_ADC   = 2'd1;
    localparam logic [DEVW-1:0] DEV_BLT   = 2'd2;

    typedef enum logic {
        FMT_SPI = 1'b0,
        FMT_MW  = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        frame_fmt_e            fmt;
        logic [CFG_WW-1:0]     width;
        logic [CFG_DIVW-1:0]   div;
    } port_cfg_t;
endpackage

// File: rtl/cs_seq_profile.sv
module cs_seq_profile
    import cs_seq_pkg::*;
#(
    parameter int TS_W    = 12,
    parameter int TS_DIV  = 7,
    parameter int ADC_W   = 8,
    parameter int ADC_DIV = 4,
    parameter int BLT_W   = 8,
    parameter int BLT_DIV = 2
) (
    input  logic [DEVW-1:0] dev_i,
    output port_cfg_t       cfg_o
);
    always_comb begin
        case (dev_i)
            DEV_TOUCH: cfg_o = '{fmt: FMT_MW,  width: CFG_WW'(TS_W),  div: CFG_DIVW'(TS_DIV)};
            DEV_ADC:   cfg_o = '{fmt: FMT_SPI, width: CFG_WW'(ADC_W), div: CFG_DIVW'(ADC_DIV)};
            DEV_BLT:   cfg_o = '{fmt: FMT_SPI, width: CFG_WW'(BLT_W), div: CFG_DIVW'(BLT_DIV)};
            default:   cfg_o = '{fmt: FMT_SPI, width: CFG_WW'(ADC_W), div: CFG_DIVW'(1)};
        endcase
    end
endmodule

// File: rtl/cs_seq_shifter.sv
module cs_seq_shifter
    import cs_seq_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CMDW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  port_cfg_t     cfg_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_word_i,
    output logic          tx_full_o,
    input  logic          pop_i,
    output logic          rx_valid_o,
    output logic [DW-1:0] rx_word_o,
    output logic          sclk_o,
    output logic          mosi_o,
    input  logic          miso_i
);
    localparam int NB_MAX = CMDW + 1 + DW;
    localparam int BW     = $clog2(NB_MAX + 1);

    typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_st_e;

    typedef struct packed {
        sh_st_e              st;
        logic [CFG_DIVW-1:0] cnt;
        logic [BW-1:0]       bitn;
        logic [DW-1:0]       hold;
        logic                full;
        logic [DW-1:0]       tsh;
        logic [DW-1:0]       rsh;
        logic [DW-1:0]       rword;
        logic                rvalid;
        logic                sclk;
    } sh_t;

    sh_t q, n;

    logic [BW-1:0] nbits, outbits, sh_amt;
    logic          capture, half_end;

    always_comb begin
        if (cfg_i.fmt == FMT_MW) begin
            nbits   = BW'(CMDW) + BW'(1) + BW'(cfg_i.width);
            outbits = BW'(CMDW);
        end else begin
            nbits   = BW'(cfg_i.width);
            outbits = BW'(cfg_i.width);
        end
        sh_amt   = BW'(DW) - outbits;
        capture  = (cfg_i.fmt == FMT_SPI) || (q.bitn > BW'(CMDW));
        half_end = (q.cnt == cfg_i.div - CFG_DIVW'(1));
    end

    always_comb begin
        n = q;
        if (load_i) begin
            n.hold = load_word_i;
            n.full = 1'b1;
        end
        if (pop_i) n.rvalid = 1'b0;
        case (q.st)
            SH_IDLE: begin
                n.sclk = 1'b0;
                if (q.full) begin
                    n.tsh  = q.hold << sh_amt;
                    n.full = 1'b0;
                    n.rsh  = '0;
                    n.cnt  = '0;
                    n.bitn = '0;
                    n.st   = SH_LOW;
                end
            end
            SH_LOW: begin
                if (half_end) begin
                    n.cnt  = '0;
                    n.sclk = 1'b1;
                    n.st   = SH_HIGH;
                    if (capture) n.rsh = {q.rsh[DW-2:0], miso_i};
                end else begin
                    n.cnt = q.cnt + CFG_DIVW'(1);
                end
            end
            SH_HIGH: begin
                if (half_end) begin
                    n.cnt  = '0;
                    n.sclk = 1'b0;
                    if (q.bitn == nbits - BW'(1)) begin
                        n.st     = SH_IDLE;
                        n.rword  = q.rsh;
                        n.rvalid = 1'b1;
                    end else begin
                        n.bitn = q.bitn + BW'(1);
                        n.tsh  = q.tsh << 1;
                        n.st   = SH_LOW;
                    end
                end else begin
                    n.cnt = q.cnt + CFG_DIVW'(1);
                end
            end
            default: n.st = SH_IDLE;
        endcase
        if (!en_i) n = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign tx_full_o  = q.full;
    assign rx_valid_o = q.rvalid;
    assign rx_word_o  = q.rword;
    assign sclk_o     = q.sclk;
    assign mosi_o     = (q.st != SH_IDLE) && q.tsh[DW-1];

    p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rvalid && !pop_i && en_i) |=> (q.rvalid && $stable(q.rword)));

    p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !sclk_o);
endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
    import cs_seq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic [DEVW-1:0] dev_i,
    input  logic [DW-1:0]   data_i,
    input  logic            tx_full_i,
    input  logic            rx_valid_i,
    input  logic [DW-1:0]   rx_word_i,
    output logic            en_o,
    output logic            load_o,
    output logic [DW-1:0]   load_word_o,
    output logic            pop_o,
    output logic [DEVW-1:0] dev_o,
    output logic [NDEV-1:0] cs_n_o,
    output logic            busy_o,
    output logic            err_o,
    output logic            done_o,
    output logic [DW-1:0]   rdata_o
);
    localparam logic [DEVW-1:0] NDEV_V = DEVW'(NDEV);

    typedef enum logic [2:0] {
        C_IDLE, C_QUIESCE, C_SELECT, C_WAIT_TX, C_HOLD, C_WAIT_RX
    } ctrl_st_e;

    typedef struct packed {
        ctrl_st_e        st;
        logic [DEVW-1:0] dev;
        logic [DW-1:0]   word;
        logic [NDEV-1:0] cs_n;
        logic            en;
        logic            busy;
        logic            err;
        logic            done;
        logic [DW-1:0]   rdata;
    } ctrl_t;

    ctrl_t q, n;
    logic  is_touch;

    assign is_touch = (q.dev == DEV_TOUCH);

    always_comb begin
        n      = q;
        n.err  = 1'b0;
        n.done = 1'b0;
        load_o = 1'b0;
        pop_o  = 1'b0;
        case (q.st)
            C_IDLE: begin
                if (start_i) begin
                    if (dev_i < NDEV_V) begin
                        n.dev  = dev_i;
                        n.word = data_i;
                        n.busy = 1'b1;
                        n.en   = 1'b0;
                        n.cs_n = '1;
                        n.st   = C_QUIESCE;
                    end else begin
                        n.err = 1'b1;
                    end
                end
            end
            C_QUIESCE: begin
                for (int i = 0; i < NDEV; i++)
                    n.cs_n[i] = (DEVW'(i) != q.dev);
                n.en = 1'b1;
                n.st = C_SELECT;
            end
            C_SELECT: begin
                load_o = is_touch;
                n.st   = is_touch ? C_WAIT_TX : C_HOLD;
            end
            C_WAIT_TX: begin
                if (!tx_full_i) n.st = C_HOLD;
            end
            C_HOLD: begin
                if (stop_i) begin
                    if (is_touch) begin
                        n.st = C_WAIT_RX;
                    end else begin
                        n.rdata = '0;
                        n.cs_n  = '1;
                        n.en    = 1'b0;
                        n.busy  = 1'b0;
                        n.done  = 1'b1;
                        n.st    = C_IDLE;
                    end
                end
            end
            C_WAIT_RX: begin
                if (rx_valid_i) begin
                    pop_o   = 1'b1;
                    n.rdata = rx_word_i;
                    n.cs_n  = '1;
                    n.en    = 1'b0;
                    n.busy  = 1'b0;
                    n.done  = 1'b1;
                    n.st    = C_IDLE;
                end
            end
            default: n.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= '1;
        end else begin
            q <= n;
        end
    end

    assign en_o        = q.en;
    assign load_word_o = q.word;
    assign dev_o       = q.dev;
    assign cs_n_o      = q.cs_n;
    assign busy_o      = q.busy;
    assign err_o       = q.err;
    assign done_o      = q.done;
    assign rdata_o     = q.rdata;

    p_one_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~q.cs_n));

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == C_IDLE && start_i && dev_i < NDEV_V) |=> q.busy);

    p_sel_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == C_HOLD && !stop_i) |=> $stable(q.cs_n));

    p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (&q.cs_n && !q.busy));

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> (!q.busy && &q.cs_n));

    p_idle_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> &q.cs_n);
endmodule

// File: rtl/cs_seq_top.sv
module cs_seq_top
    import cs_seq_pkg::*;
#(
    parameter int DW      = 16,
    parameter int CMDW    = 8,
    parameter int TS_W    = 12,
    parameter int TS_DIV  = 7,
    parameter int ADC_W   = 8,
    parameter int ADC_DIV = 4,
    parameter int BLT_W   = 8,
    parameter int BLT_DIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [1:0]    dev_i,
    input  logic [DW-1:0] data_i,
    output logic          busy_o,
    output logic          err_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    output logic [2:0]    cs_n_o,
    output logic          sclk_o,
    output logic          mosi_o,
    input  logic          miso_i
);
    logic            en, load, tx_full, pop, rx_valid;
    logic [DW-1:0]   load_word, rx_word;
    logic [DEVW-1:0] cur_dev;
    port_cfg_t       cfg;

    cs_seq_ctrl #(.DW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .dev_i       (dev_i),
        .data_i      (data_i),
        .tx_full_i   (tx_full),
        .rx_valid_i  (rx_valid),
        .rx_word_i   (rx_word),
        .en_o        (en),
        .load_o      (load),
        .load_word_o (load_word),
        .pop_o       (pop),
        .dev_o       (cur_dev),
        .cs_n_o      (cs_n_o),
        .busy_o      (busy_o),
        .err_o       (err_o),
        .done_o      (done_o),
        .rdata_o     (rdata_o)
    );

    cs_seq_profile #(
        .TS_W(TS_W), .TS_DIV(TS_DIV), .ADC_W(ADC_W),
        .ADC_DIV(ADC_DIV), .BLT_W(BLT_W), .BLT_DIV(BLT_DIV)
    ) u_profile (
        .dev_i (cur_dev),
        .cfg_o (cfg)
    );

    cs_seq_shifter #(.DW(DW), .CMDW(CMDW)) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .cfg_i       (cfg),
        .load_i      (load),
        .load_word_i (load_word),
        .tx_full_o   (tx_full),
        .pop_i       (pop),
        .rx_valid_o  (rx_valid),
        .rx_word_o   (rx_word),
        .sclk_o      (sclk_o),
        .mosi_o      (mosi_o),
        .miso_i      (miso_i)
    );
endmodule

// File: tb/cs_seq_top_tb.sv
module cs_seq_top_tb;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, stop_i = 1'b0;
    logic [1:0]    dev_i = '0;
    logic [DW-1:0] data_i = '0;
    logic          busy_o, err_o, done_o, sclk_o, mosi_o;
    logic          miso_i = 1'b0;
    logic [DW-1:0] rdata_o;
    logic [2:0]    cs_n_o;

    always #4 clk = ~clk;

    cs_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .dev_i(dev_i), .data_i(data_i), .busy_o(busy_o), .err_o(err_o),
        .done_o(done_o), .rdata_o(rdata_o), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic [DW-1:0] exp_v;
    string         exp_t;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // slave model of the touch controller
    logic       sclk_p = 1'b0;
    int         k = 0;
    int         rises = 0;
    logic [7:0] cmd_got = '0;
    logic [11:0] reply = '0;

    always @(negedge clk) begin
        if (sclk_o && !sclk_p) rises <= rises + 1;
        if (cs_n_o[0]) begin
            k      <= 0;
            miso_i <= 1'b0;
        end else begin
            if (sclk_o && !sclk_p) begin
                if (k < 8) cmd_got <= {cmd_got[6:0], mosi_o};
                k <= k + 1;
            end
            if (!sclk_o && sclk_p && k >= 9 && k <= 20)
                miso_i <= reply[11-(k-9)];
        end
        sclk_p <= sclk_o;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "done with no pending stop", 1, 0);
            end else begin
                exp_v = exp_q.pop_front();
                exp_t = tag_q.pop_front();
                chk(rdata_o == exp_v, exp_t, "result word", rdata_o, exp_v);
                chk(cs_n_o == 3'b111 && !busy_o, "R7", "release at done",
                    {busy_o, cs_n_o}, 7);
            end
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy_o; i++) @(negedge clk);
    endtask

    task automatic txn(input logic [1:0] dev, input logic [DW-1:0] data,
                       input logic [11:0] rep, input bit early);
        int r0;
        int hi;
        logic [2:0] sel;
        sel   = 3'(~(3'b001 << dev));
        reply = rep;
        r0    = rises;
        @(negedge clk); start_i = 1'b1; dev_i = dev; data_i = data;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o, "R9", "busy after start", busy_o, 1);
        chk(cs_n_o == 3'b111, "R2", "all high during quiesce", cs_n_o, 7);
        @(negedge clk);
        chk(cs_n_o == sel, "R2", "only chosen select low", cs_n_o, sel);
        if (dev == 2'd0) begin
            if (early) begin
                repeat (10) @(negedge clk);
            end else begin
                for (int i = 0; i < 100 && !sclk_o; i++) @(negedge clk);
                hi = 0;
                for (int i = 0; i < 100 && sclk_o; i++) begin hi++; @(negedge clk); end
                chk(hi == 7, "R3", "sclk high half period", hi, 7);
                for (int i = 0; i < 2000 && (rises - r0) < 21; i++) @(negedge clk);
                repeat (20) @(negedge clk);
                chk(rises - r0 == 21, "R3", "rising edges per frame", rises - r0, 21);
                chk(cmd_got == data[7:0], "R3", "command seen by slave", cmd_got, data[7:0]);
            end
        end else begin
            repeat (60) @(negedge clk);
            chk(rises == r0, "R4", "no clock while selected", rises - r0, 0);
            chk(cs_n_o == sel, "R4", "select held", cs_n_o, sel);
        end
        exp_q.push_back(dev == 2'd0 ? {4'h0, rep} : '0);
        tag_q.push_back(dev == 2'd0 ? "R5" : "R6");
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        if (dev == 2'd0 && early) begin
            repeat (3) @(negedge clk);
            chk(busy_o && !done_o, "R5", "stop waits for reply", busy_o, 1);
        end else if (dev != 2'd0) begin
            chk(!busy_o, "R6", "immediate completion", busy_o, 0);
        end
        wait_idle();
        if (dev == 2'd0 && early)
            chk(cmd_got == data[7:0], "R3", "command seen by slave", cmd_got, data[7:0]);
        @(negedge clk);
        chk(cs_n_o == 3'b111, "R7", "selects high after stop", cs_n_o, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n_o == 3'b111, "R1", "reset selects", cs_n_o, 7);
        chk(!busy_o && !err_o && !done_o && !sclk_o, "R1", "reset flags",
            {busy_o, err_o, done_o, sclk_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        txn(2'd0, 16'h00A5, 12'hABC, 1'b0);
        txn(2'd1, 16'h0042, 12'h000, 1'b0);
        txn(2'd2, 16'h0013, 12'h000, 1'b0);
        txn(2'd0, 16'h0083, 12'h001, 1'b1);
        txn(2'd0, 16'h00FF, 12'hFFF, 1'b0);

        // invalid device code
        @(negedge clk); start_i = 1'b1; dev_i = 2'd3;
        @(negedge clk); start_i = 1'b0;
        chk(err_o, "R8", "error pulse", err_o, 1);
        chk(!busy_o && cs_n_o == 3'b111, "R8", "nothing selected",
            {busy_o, cs_n_o}, 7);
        @(negedge clk);
        chk(!err_o, "R8", "error lasts one cycle", err_o, 0);

        // start while busy is ignored
        @(negedge clk); start_i = 1'b1; dev_i = 2'd1;
        @(negedge clk); start_i = 1'b0;
        repeat (5) @(negedge clk);
        begin
            int r0;
            r0 = rises;
            start_i = 1'b1; dev_i = 2'd0; data_i = 16'h00C3;
            @(negedge clk); start_i = 1'b0;
            repeat (40) @(negedge clk);
            chk(cs_n_o == 3'b101, "R9", "select kept on busy start", cs_n_o, 5);
            chk(rises == r0, "R9", "no frame on busy start", rises - r0, 0);
        end
        exp_q.push_back('0);
        tag_q.push_back("R6");
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        wait_idle();

        // stop while idle
        repeat (3) @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy_o && cs_n_o == 3'b111, "R10", "idle stop has no effect",
            {busy_o, cs_n_o}, 7);
        chk(exp_q.size() == 0, "R5", "all results delivered", exp_q.size(), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run hung actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule